// File: doc/BRIEF.md
# Spectral Test Pattern Generator

This block produces test vectors for a combinational circuit under test during built-in self-test. An external Hadamard generator supplies a bus of Walsh waveforms. Each lane of the output vector, one per input of the circuit under test, is set up with three settings: the index of the Walsh line it should follow, a one-probability for a weighted pseudo-random bit, and a mixing proportion. The mixing proportion says how often the random bit replaces the Walsh bit. Each lane therefore carries a noisy copy of its chosen spectral component. The random bits come from a cellular-automaton register that mixes rule 90 and rule 150 cells with null boundaries. Small AND/OR networks shape these bits into the requested weights.

A tester can reseed the register in two ways. A parallel port loads the register at once. A serial scan port shifts a seed into a holding register, and an apply strobe then copies it into the automaton. In external-tester mode the generator emits exactly one vector per loaded seed. In hybrid mode it runs freely, one vector per clock. It can also restore the held seed after a programmable number of vectors, so a tester can steer long stretches of on-chip patterns with very little data.

Top module: `spectral_tpg`

## Requirements
- R1: After reset `vec_out` is all zero, `vec_valid` is 0, the automaton holds `ZERO_SUB`, the holding register and reseed counter are zero, and external-tester mode without a load emits nothing.
- R2: On each advance the automaton cell i takes s[i-1] XOR s[i+1] XOR (RULE_MASK[i] AND s[i]), with cells beyond either end read as 0.
- R3: Lane L draws raw bits r0..r4 from automaton cells (L*5+k) mod CA_BITS, k=0..4, in the state before the advance. The weight code is 3 bits: 1 gives r0&r1, 2 gives r0|(r1&r2), 3 gives r0|r1, 4 gives r0|r1|r2, and 0 or 5..7 give r0.
- R4: The mix code is 2 bits. Code 0 always outputs the Walsh bit. Code 1 replaces it with the weighted bit when r3&r4. Code 2 replaces it when r3. Code 3 always outputs the weighted bit.
- R5: A lane's Walsh bit is `walsh_in[comp]`, where comp is the lane's WALSH_ORDER-bit field in `cfg_comp`, with lane L at bits [L*WALSH_ORDER +: WALSH_ORDER]. The same packing holds for `cfg_weight` (3 bits) and `cfg_mix` (2 bits).
- R6: A parallel load copies `seed_par` into the holding register and into the automaton, except that a zero value puts `ZERO_SUB` into the automaton.
- R7: A serial shift moves the holding register left and takes `seed_sin` at bit 0, without disturbing pattern generation. An apply copies the held value, with zero replaced by `ZERO_SUB`, into the automaton.
- R8: In external-tester mode (`hbm_mode`=0), each load or apply leads to exactly one vector, with `vec_valid` high one clock after the load cycle. At all other times `vec_valid` is low and `vec_out` holds its last value.
- R9: In hybrid mode (`hbm_mode`=1), a vector is emitted on every clock without a load. With a nonzero `reseed_interval` N, every Nth advance after a load loads the automaton from the held seed instead of stepping it. A value of 0 never reseeds.
- R10: A load or apply wins over pattern advance in the same cycle: no vector is produced and the reseed count restarts from zero.
- R11: Between tester strobes in the same cycle, a parallel load wins over apply, and apply wins over a serial shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | BIST clock |
| rst_n | input | 1 | Active-low reset |
| hbm_mode | input | 1 | 1 = free-running hybrid mode, 0 = one vector per seed |
| walsh_in | input | 2**WALSH_ORDER | Walsh waveforms from the Hadamard generator |
| cfg_comp | input | NUM_IN*WALSH_ORDER | Per-lane Walsh line index |
| cfg_weight | input | NUM_IN*3 | Per-lane weight code |
| cfg_mix | input | NUM_IN*2 | Per-lane mixing code |
| seed_par | input | CA_BITS | Parallel seed |
| seed_par_load | input | 1 | Parallel load strobe |
| seed_sin | input | 1 | Serial seed bit |
| seed_shift | input | 1 | Serial shift strobe |
| seed_apply | input | 1 | Copy held seed into the automaton |
| reseed_interval | input | INTERVAL_W | Advances between hybrid reseeds, 0 = off |
| vec_out | output | NUM_IN | Test vector to the circuit under test |
| vec_valid | output | 1 | A new vector was produced this cycle |

## Verification
A tester load can land in the same cycle as a pattern advance. It can also land on the exact advance where the hybrid reseed counter expires. The bench causes both in hybrid mode by strobing parallel loads and applies every few clocks against short reseed intervals, and by raising parallel load, apply and shift together. A cycle-accurate model computed from the requirements then expects no vector that cycle, the tester's seed in the automaton, a restarted count, and the shift discarded. Every vector and valid flag is compared against that model.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int RAND_PER_LANE = 5;

    typedef enum logic [2:0] {
        WGT_HALF          = 3'd0,
        WGT_QUARTER       = 3'd1,
        WGT_FIVE_EIGHTHS  = 3'd2,
        WGT_THREE_QUARTER = 3'd3,
        WGT_SEVEN_EIGHTHS = 3'd4
    } weight_e;

    typedef enum logic [1:0] {
        MIX_SPECTRAL = 2'd0,
        MIX_QUARTER  = 2'd1,
        MIX_HALF     = 2'd2,
        MIX_RANDOM   = 2'd3
    } mix_e;

    // Shape three fair bits into the requested one-probability.
    function automatic logic shape_weight(input logic [2:0] code,
                                          input logic a, input logic b,
                                          input logic c);
        logic r;
        case (code)
            WGT_QUARTER:       r = a & b;
            WGT_FIVE_EIGHTHS:  r = a | (b & c);
            WGT_THREE_QUARTER: r = a | b;
            WGT_SEVEN_EIGHTHS: r = a | b | c;
            default:           r = a;
        endcase
        return r;
    endfunction

    // Decide whether the random bit replaces the spectral bit.
    function automatic logic take_random(input logic [1:0] code,
                                         input logic d, input logic e);
        logic r;
        case (code)
            MIX_SPECTRAL: r = 1'b0;
            MIX_QUARTER:  r = d & e;
            MIX_HALF:     r = d;
            default:      r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tpg_ca_step.sv
module tpg_ca_step #(
    parameter int          CA_BITS   = 16,
    parameter logic [CA_BITS-1:0] RULE_MASK = 16'h4A37
) (
    input  logic [CA_BITS-1:0] state_i,
    output logic [CA_BITS-1:0] state_o
);

    for (genvar i = 0; i < CA_BITS; i++) begin : g_cell
        logic left_b;
        logic right_b;
        if (i == 0) begin : g_lo_edge
            assign left_b = 1'b0;
        end else begin : g_lo_link
            assign left_b = state_i[i-1];
        end
        if (i == CA_BITS - 1) begin : g_hi_edge
            assign right_b = 1'b0;
        end else begin : g_hi_link
            assign right_b = state_i[i+1];
        end
        assign state_o[i] = left_b ^ right_b ^ (RULE_MASK[i] & state_i[i]);
    end

endmodule

// File: rtl/tpg_bit_mixer.sv
module tpg_bit_mixer
    import tpg_pkg::*;
#(
    parameter int CA_BITS     = 16,
    parameter int WALSH_ORDER = 3,
    parameter int LANE        = 0
) (
    input  logic [CA_BITS-1:0]          ca_state,
    input  logic [(1<<WALSH_ORDER)-1:0] walsh_in,
    input  logic [WALSH_ORDER-1:0]      comp,
    input  logic [2:0]                  weight,
    input  logic [1:0]                  mix,
    output logic                        bit_o
);

    logic [RAND_PER_LANE-1:0] raw;

    for (genvar k = 0; k < RAND_PER_LANE; k++) begin : g_tap
        localparam int TAP = (LANE * RAND_PER_LANE + k) % CA_BITS;
        assign raw[k] = ca_state[TAP];
    end

    logic spectral_b;
    logic weighted_b;

    always_comb begin
        spectral_b = walsh_in[comp];
        weighted_b = shape_weight(weight, raw[0], raw[1], raw[2]);
        bit_o      = take_random(mix, raw[3], raw[4]) ? weighted_b : spectral_b;
    end

endmodule

// File: rtl/tpg_seed_ctrl.sv
module tpg_seed_ctrl #(
    parameter int                 CA_BITS    = 16,
    parameter int                 INTERVAL_W = 8,
    parameter logic [CA_BITS-1:0] ZERO_SUB   = 16'h0001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hbm_mode,
    input  logic [CA_BITS-1:0]    seed_par,
    input  logic                  seed_par_load,
    input  logic                  seed_sin,
    input  logic                  seed_shift,
    input  logic                  seed_apply,
    input  logic [INTERVAL_W-1:0] reseed_interval,
    output logic                  do_load,
    output logic                  do_adv,
    output logic                  do_reseed,
    output logic [CA_BITS-1:0]    seed_val
);

    typedef struct packed {
        logic [CA_BITS-1:0]    shadow;
        logic [INTERVAL_W-1:0] cnt;
        logic                  pend;
    } ctrl_t;

    ctrl_t st_d, st_q;

    function automatic logic [CA_BITS-1:0] nonzero(input logic [CA_BITS-1:0] v);
        return (v == '0) ? ZERO_SUB : v;
    endfunction

    always_comb begin
        st_d      = st_q;
        do_load   = 1'b0;
        do_adv    = 1'b0;
        do_reseed = 1'b0;
        seed_val  = nonzero(st_q.shadow);
        if (seed_par_load) begin
            st_d.shadow = seed_par;
            st_d.cnt    = '0;
            st_d.pend   = 1'b1;
            do_load     = 1'b1;
            seed_val    = nonzero(seed_par);
        end else if (seed_apply) begin
            st_d.cnt  = '0;
            st_d.pend = 1'b1;
            do_load   = 1'b1;
        end else begin
            if (seed_shift) begin
                st_d.shadow = {st_q.shadow[CA_BITS-2:0], seed_sin};
            end
            st_d.pend = 1'b0;
            if (hbm_mode) begin
                do_adv = 1'b1;
                if (reseed_interval != '0) begin
                    if (st_q.cnt == reseed_interval - 1'b1) begin
                        do_reseed = 1'b1;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    st_d.cnt = '0;
                end
            end else begin
                do_adv   = st_q.pend;
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spectral_tpg.sv
module spectral_tpg
    import tpg_pkg::*;
#(
    parameter int                 NUM_IN      = 4,
    parameter int                 WALSH_ORDER = 3,
    parameter int                 CA_BITS     = 16,
    parameter int                 INTERVAL_W  = 8,
    parameter logic [CA_BITS-1:0] RULE_MASK   = 16'h4A37,
    parameter logic [CA_BITS-1:0] ZERO_SUB    = 16'h0001
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            hbm_mode,
    input  logic [(1<<WALSH_ORDER)-1:0]     walsh_in,
    input  logic [NUM_IN*WALSH_ORDER-1:0]   cfg_comp,
    input  logic [NUM_IN*3-1:0]             cfg_weight,
    input  logic [NUM_IN*2-1:0]             cfg_mix,
    input  logic [CA_BITS-1:0]              seed_par,
    input  logic                            seed_par_load,
    input  logic                            seed_sin,
    input  logic                            seed_shift,
    input  logic                            seed_apply,
    input  logic [INTERVAL_W-1:0]           reseed_interval,
    output logic [NUM_IN-1:0]               vec_out,
    output logic                            vec_valid
);

    typedef struct packed {
        logic [CA_BITS-1:0] ca;
        logic [NUM_IN-1:0]  vec;
        logic               vld;
    } gen_t;

    gen_t st_d, st_q;

    logic               do_load;
    logic               do_adv;
    logic               do_reseed;
    logic [CA_BITS-1:0] seed_val;
    logic [CA_BITS-1:0] ca_next;
    logic [NUM_IN-1:0]  lane_bits;

    tpg_seed_ctrl #(
        .CA_BITS   (CA_BITS),
        .INTERVAL_W(INTERVAL_W),
        .ZERO_SUB  (ZERO_SUB)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .hbm_mode       (hbm_mode),
        .seed_par       (seed_par),
        .seed_par_load  (seed_par_load),
        .seed_sin       (seed_sin),
        .seed_shift     (seed_shift),
        .seed_apply     (seed_apply),
        .reseed_interval(reseed_interval),
        .do_load        (do_load),
        .do_adv         (do_adv),
        .do_reseed      (do_reseed),
        .seed_val       (seed_val)
    );

    tpg_ca_step #(
        .CA_BITS  (CA_BITS),
        .RULE_MASK(RULE_MASK)
    ) u_step (
        .state_i(st_q.ca),
        .state_o(ca_next)
    );

    for (genvar l = 0; l < NUM_IN; l++) begin : g_lane
        tpg_bit_mixer #(
            .CA_BITS    (CA_BITS),
            .WALSH_ORDER(WALSH_ORDER),
            .LANE       (l)
        ) u_mix (
            .ca_state(st_q.ca),
            .walsh_in(walsh_in),
            .comp    (cfg_comp[l*WALSH_ORDER +: WALSH_ORDER]),
            .weight  (cfg_weight[l*3 +: 3]),
            .mix     (cfg_mix[l*2 +: 2]),
            .bit_o   (lane_bits[l])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (do_load) begin
            st_d.ca = seed_val;
        end else if (do_adv) begin
            st_d.vec = lane_bits;
            st_d.vld = 1'b1;
            st_d.ca  = do_reseed ? seed_val : ca_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ca  <= ZERO_SUB;
            st_q.vec <= '0;
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_out   = st_q.vec;
    assign vec_valid = st_q.vld;

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int NUM_IN      = 4,
    parameter int WALSH_ORDER = 3,
    parameter int CA_BITS     = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          hbm_mode,
    input logic [(1<<WALSH_ORDER)-1:0]   walsh_in,
    input logic [NUM_IN*WALSH_ORDER-1:0] cfg_comp,
    input logic [NUM_IN*2-1:0]           cfg_mix,
    input logic                          seed_par_load,
    input logic                          seed_apply,
    input logic [NUM_IN-1:0]             vec_out,
    input logic                          vec_valid,
    input logic [CA_BITS-1:0]            ca_state
);

    assert_load_blocks_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_par_load || seed_apply) |=> !vec_valid);

    assert_single_vector_per_seed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !hbm_mode) |=> !vec_valid);

    assert_free_run_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hbm_mode && !seed_par_load && !seed_apply) |=> vec_valid);

    assert_spectral_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(cfg_mix[1:0] == 2'd0))
            |-> (vec_out[0] == $past(walsh_in[cfg_comp[WALSH_ORDER-1:0]])));

    assert_state_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ca_state != '0);

endmodule

bind spectral_tpg tpg_checker #(
    .NUM_IN     (NUM_IN),
    .WALSH_ORDER(WALSH_ORDER),
    .CA_BITS    (CA_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hbm_mode     (hbm_mode),
    .walsh_in     (walsh_in),
    .cfg_comp     (cfg_comp),
    .cfg_mix      (cfg_mix),
    .seed_par_load(seed_par_load),
    .seed_apply   (seed_apply),
    .vec_out      (vec_out),
    .vec_valid    (vec_valid),
    .ca_state     (st_q.ca)
);

// File: tb/spectral_tpg_tb.sv
module spectral_tpg_tb;

    localparam int NI = 4;
    localparam int WO = 3;
    localparam int WW = 1 << WO;
    localparam int CB = 16;
    localparam int IW = 8;
    localparam logic [CB-1:0] RMASK = 16'h4A37;
    localparam logic [CB-1:0] ZSUB  = 16'h0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hbm_mode = 1'b0;
    logic [WW-1:0] walsh_in = '0;
    logic [NI*WO-1:0] cfg_comp = '0;
    logic [NI*3-1:0]  cfg_weight = '0;
    logic [NI*2-1:0]  cfg_mix = '0;
    logic [CB-1:0] seed_par = '0;
    logic          seed_par_load = 1'b0;
    logic          seed_sin = 1'b0;
    logic          seed_shift = 1'b0;
    logic          seed_apply = 1'b0;
    logic [IW-1:0] reseed_interval = '0;
    logic [NI-1:0] vec_out;
    logic          vec_valid;

    int checks = 0;
    int errors = 0;
    int tcount = 0;

    logic [CB-1:0] m_ca = ZSUB;
    logic [CB-1:0] m_sh = '0;
    logic [IW-1:0] m_cnt = '0;
    logic          m_pend = 1'b0;
    logic [NI-1:0] m_vec = '0;
    logic          m_vld = 1'b0;

    always #4 clk = ~clk;

    spectral_tpg #(
        .NUM_IN(NI), .WALSH_ORDER(WO), .CA_BITS(CB), .INTERVAL_W(IW),
        .RULE_MASK(RMASK), .ZERO_SUB(ZSUB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hbm_mode(hbm_mode), .walsh_in(walsh_in),
        .cfg_comp(cfg_comp), .cfg_weight(cfg_weight), .cfg_mix(cfg_mix),
        .seed_par(seed_par), .seed_par_load(seed_par_load), .seed_sin(seed_sin),
        .seed_shift(seed_shift), .seed_apply(seed_apply),
        .reseed_interval(reseed_interval), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    function automatic logic [WW-1:0] walsh_of(input int t);
        logic [WW-1:0] w;
        for (int k = 0; k < WW; k++) begin
            w[k] = ^(k[WO-1:0] & t[WO-1:0]);
        end
        return w;
    endfunction

    function automatic logic [CB-1:0] nz(input logic [CB-1:0] v);
        return (v == '0) ? ZSUB : v;
    endfunction

    function automatic logic [CB-1:0] ca_model(input logic [CB-1:0] s);
        logic [CB-1:0] n;
        for (int i = 0; i < CB; i++) begin
            logic l, r;
            l = (i == 0) ? 1'b0 : s[i-1];
            r = (i == CB - 1) ? 1'b0 : s[i+1];
            n[i] = l ^ r ^ (RMASK[i] & s[i]);
        end
        return n;
    endfunction

    function automatic logic [NI-1:0] vec_model(input logic [CB-1:0] s);
        logic [NI-1:0] v;
        for (int l = 0; l < NI; l++) begin
            logic [4:0] rb;
            logic wb, sb, take;
            int c, wc, mc;
            for (int k = 0; k < 5; k++) rb[k] = s[(l*5+k) % CB];
            c  = int'(cfg_comp[l*WO +: WO]);
            wc = int'(cfg_weight[l*3 +: 3]);
            mc = int'(cfg_mix[l*2 +: 2]);
            sb = walsh_in[c];
            if (wc == 1)      wb = rb[0] & rb[1];
            else if (wc == 2) wb = rb[0] | (rb[1] & rb[2]);
            else if (wc == 3) wb = rb[0] | rb[1];
            else if (wc == 4) wb = rb[0] | rb[1] | rb[2];
            else              wb = rb[0];
            if (mc == 0)      take = 1'b0;
            else if (mc == 1) take = rb[3] & rb[4];
            else if (mc == 2) take = rb[3];
            else              take = 1'b1;
            v[l] = take ? wb : sb;
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        logic [CB-1:0] n_ca, n_sh;
        logic [IW-1:0] n_cnt;
        logic n_pend, n_vld, adv, rs;
        logic [NI-1:0] n_vec;
        n_ca = m_ca; n_sh = m_sh; n_cnt = m_cnt; n_pend = m_pend;
        n_vec = m_vec; n_vld = 1'b0; adv = 1'b0; rs = 1'b0;
        if (seed_par_load) begin
            n_sh = seed_par; n_ca = nz(seed_par); n_cnt = '0; n_pend = 1'b1;
        end else if (seed_apply) begin
            n_ca = nz(m_sh); n_cnt = '0; n_pend = 1'b1;
        end else begin
            if (seed_shift) n_sh = {m_sh[CB-2:0], seed_sin};
            n_pend = 1'b0;
            if (hbm_mode) begin
                adv = 1'b1;
                if (reseed_interval == 0) n_cnt = '0;
                else if (m_cnt == reseed_interval - 1) begin rs = 1'b1; n_cnt = '0; end
                else n_cnt = m_cnt + 1;
            end else begin
                adv = m_pend; n_cnt = '0;
            end
            if (adv) begin
                n_vec = vec_model(m_ca);
                n_vld = 1'b1;
                n_ca  = rs ? nz(m_sh) : ca_model(m_ca);
            end
        end
        @(posedge clk);
        #1;
        m_ca = n_ca; m_sh = n_sh; m_cnt = n_cnt; m_pend = n_pend;
        m_vec = n_vec; m_vld = n_vld;
        check({tag, " vector"}, 32'(vec_out), 32'(m_vec));
        check({tag, " valid"}, 32'(vec_valid), 32'(m_vld));
        tcount++;
        walsh_in = walsh_of(tcount);
    endtask

    task automatic clear_strobes();
        seed_par_load = 1'b0; seed_apply = 1'b0; seed_shift = 1'b0; seed_sin = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset vector", 32'(vec_out), 32'd0);
        check("R1 reset valid", 32'(vec_valid), 32'd0);
        rst_n = 1'b1;
        walsh_in = walsh_of(0);
        repeat (3) tick("R1 idle tester mode");

        // R2: pure random lanes expose raw automaton taps
        hbm_mode = 1'b1; cfg_mix = '1; cfg_weight = '0;
        repeat (24) tick("R2 automaton step");

        // R5: spectral-only lanes, sweep every Walsh index
        cfg_mix = '0;
        for (int c = 0; c < WW; c++) begin
            for (int l = 0; l < NI; l++) cfg_comp[l*WO +: WO] = WO'((c + l*3) % WW);
            repeat (8) tick("R5 Walsh index");
        end

        // R3: every weight code on every lane
        cfg_mix = '1;
        for (int w = 0; w < 8; w++) begin
            for (int l = 0; l < NI; l++) cfg_weight[l*3 +: 3] = 3'((w + l) % 8);
            repeat (6) tick("R3 weight code");
        end

        // R4: every mixing code with mixed weights
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < NI; l++) begin
                cfg_mix[l*2 +: 2]    = 2'((m + l) % 4);
                cfg_weight[l*3 +: 3] = 3'((m*3 + l) % 5);
                cfg_comp[l*WO +: WO] = WO'((m + 2*l + 1) % WW);
            end
            repeat (10) tick("R4 mix code");
        end

        // R6: parallel loads, including the zero seed
        seed_par = '0; seed_par_load = 1'b1; tick("R6 zero seed load");
        clear_strobes(); repeat (6) tick("R6 after zero seed");
        seed_par = 16'hBEEF; seed_par_load = 1'b1; tick("R6 parallel load");
        clear_strobes(); repeat (6) tick("R6 after load");

        // R7: serial shift during generation, then apply
        for (int b = CB - 1; b >= 0; b--) begin
            logic [CB-1:0] s;
            s = 16'h1234;
            seed_shift = 1'b1; seed_sin = s[b];
            tick("R7 serial shift");
        end
        clear_strobes(); seed_apply = 1'b1; tick("R7 apply");
        clear_strobes(); repeat (6) tick("R7 after apply");

        // R9: periodic reseed from held seed
        reseed_interval = 8'd5; repeat (30) tick("R9 interval five");
        reseed_interval = 8'd1; repeat (8) tick("R9 interval one");
        reseed_interval = 8'd0; repeat (8) tick("R9 no reseed");

        // R10: loads colliding with advance and reseed boundary
        reseed_interval = 8'd4;
        for (int k = 0; k < 24; k++) begin
            clear_strobes();
            if (k % 4 == 3) begin seed_par = 16'h0F0F ^ 16'(k); seed_par_load = 1'b1; end
            else if (k % 7 == 5) seed_apply = 1'b1;
            tick("R10 load over advance");
        end
        clear_strobes();

        // R8: one vector per seed in tester mode
        hbm_mode = 1'b0;
        repeat (3) tick("R8 idle");
        for (int k = 0; k < 6; k++) begin
            seed_par = 16'hA5A5 + 16'(k*77); seed_par_load = 1'b1; tick("R8 load");
            clear_strobes(); repeat (3) tick("R8 single vector");
        end
        seed_apply = 1'b1; tick("R8 apply");
        clear_strobes(); repeat (3) tick("R8 after apply");
        seed_shift = 1'b1; seed_sin = 1'b1; repeat (4) tick("R8 shift only");
        clear_strobes();

        // R11: strobe priority
        hbm_mode = 1'b1;
        seed_par = 16'h7001; seed_par_load = 1'b1; seed_apply = 1'b1;
        seed_shift = 1'b1; seed_sin = 1'b1; tick("R11 all strobes");
        clear_strobes(); repeat (3) tick("R11 after all");
        seed_apply = 1'b1; seed_shift = 1'b1; seed_sin = 1'b1; tick("R11 apply over shift");
        clear_strobes(); repeat (3) tick("R11 after apply");
        seed_apply = 1'b1; tick("R11 reapply unchanged seed");
        clear_strobes(); repeat (4) tick("R11 tail");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule